// File: doc/BRIEF.md
# Four-Channel Dual-Address DMA Engine

This block moves words from one place in memory to another on behalf of four independent channels that share a single memory bus. Software programs each channel through a small register-write port. It sets a source address, a destination address, a unit count and a mode word, and setting the enable bit in the mode word arms the channel. Each armed channel then waits on its own request line.

When one or more armed channels request, a fixed-priority arbiter picks one. The engine asks for the bus and waits for the grant. It then runs dual-address units: a read at the source, followed by a write of that word to the destination. A channel may instead treat its source register as a pointer. In that case every unit first reads a pointer word, and the value found there is the address of the data read.

Bus ownership follows the channel's mode. In cycle-steal mode the bus is handed back after every unit. In burst mode the engine keeps the bus until the count is exhausted. When the last unit is written, the channel disarms itself and pulses its done flag.

Top module: `dma4_engine`

## Requirements
- R1: When several armed channels with a nonzero count request at the same moment of arbitration, the lowest-numbered channel is served first.
- R2: Every unit is a read cycle at the source address followed by a write cycle at the destination address that carries the word just read (mem_we low for reads, high for writes).
- R3: With the indirect bit (mode bit 2) set, each unit begins with a read at the source register address. The returned word is then used as the address of the data read.
- R4: In cycle-steal mode (mode bit 1 = 0), bus_req drops in the cycle after each unit's write is acknowledged, and the next unit is arbitrated afresh. A channel moving N units therefore raises bus_req N times.
- R5: In burst mode (mode bit 1 = 1), bus_req stays high from the first unit to the last, and a higher-priority request that arrives during the burst is served only after the burst ends.
- R6: After each unit, the source register (the pointer address in indirect mode) steps by its field in mode bits 4:3, and the destination by its field in mode bits 6:5. The field encodings are 01 for +1, 10 for -1, and 00 or 11 for no change.
- R7: The count falls by one for each completed unit. On the last unit the channel clears its enable and raises its done bit for exactly one cycle, with at most one done bit high at a time. The channel then does not act on further requests until it is reprogrammed.
- R8: A memory access holds mem_req, mem_addr and mem_we steady until mem_ack is seen, and only then does the engine move to the next phase.
- R9: A request from a channel whose enable (mode bit 0) is clear, or whose count is zero, causes no bus request.
- R10: The register write port selects the field with cfg_sel (0 source, 1 destination, 2 count, 3 mode). No memory access is made unless bus_req and bus_gnt are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Field addressed by the write |
| cfg_wdata | input | W | Write data |
| dreq | input | NCH | Per-channel transfer request |
| bus_req | output | 1 | Request for ownership of the memory bus |
| bus_gnt | input | 1 | Bus ownership granted |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Access address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| done | output | NCH | One-cycle pulse when a channel finishes |

## Verification
Transfers are run with every pairing of incrementing, decrementing and fixed source and destination stepping. This separates a wrong step direction, which scatters words, from a missing step, which repeats one word. Cycle-steal and burst runs are told apart by how many times bus_req rises, and indirect runs by their three accesses per unit and by data fetched through pointer words. Directed cases place two simultaneous requests to expose the priority order, a late high-priority request during a burst to expose preemption, and disabled or zero-count channels to show that nothing reaches the bus. Random memory wait states and grant delays test the hold-until-acknowledge rule.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef struct packed {
    logic [1:0] dst_step;
    logic [1:0] src_step;
    logic       indirect;
    logic       burst;
    logic       en;
  } ch_mode_t;

  localparam int MODE_BITS = $bits(ch_mode_t);

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_MODE = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_PTR,
    ST_READ,
    ST_WRITE
  } seq_state_e;

endpackage

// File: rtl/dma4_chregs.sv
module dma4_chregs
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 32,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CHW-1:0]        cfg_ch,
  input  logic [1:0]            cfg_sel,
  input  logic [W-1:0]          cfg_wdata,
  input  logic                  upd,
  input  logic [CHW-1:0]        upd_ch,
  output logic [NCH-1:0][W-1:0] src_o,
  output logic [NCH-1:0][W-1:0] dst_o,
  output logic [NCH-1:0]        last_o,
  output logic [NCH-1:0]        burst_o,
  output logic [NCH-1:0]        ind_o,
  output logic [NCH-1:0]        elig_o,
  output logic [NCH-1:0]        done_o
);

  localparam logic [W-1:0]  ONE_W = W'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  function automatic logic [W-1:0] stepped(input logic [W-1:0] a, input logic [1:0] s);
    case (s)
      2'b01:   return a + ONE_W;
      2'b10:   return a - ONE_W;
      default: return a;
    endcase
  endfunction

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0]  src_r;
    logic [W-1:0]  dst_r;
    logic [CW-1:0] cnt_r;
    ch_mode_t      mode_r;
    logic          done_r;
    logic          wr_hit;
    logic          upd_hit;

    assign wr_hit  = cfg_we && (cfg_ch == CHW'(g));
    assign upd_hit = upd && (upd_ch == CHW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        src_r  <= '0;
        dst_r  <= '0;
        cnt_r  <= '0;
        mode_r <= '0;
        done_r <= 1'b0;
      end else begin
        done_r <= 1'b0;
        if (wr_hit) begin
          case (sel)
            SEL_SRC:  src_r  <= cfg_wdata;
            SEL_DST:  dst_r  <= cfg_wdata;
            SEL_CNT:  cnt_r  <= cfg_wdata[CW-1:0];
            default:  mode_r <= ch_mode_t'(cfg_wdata[MODE_BITS-1:0]);
          endcase
        end else if (upd_hit) begin
          src_r <= stepped(src_r, mode_r.src_step);
          dst_r <= stepped(dst_r, mode_r.dst_step);
          cnt_r <= cnt_r - ONE_C;
          if (cnt_r == ONE_C) begin
            mode_r.en <= 1'b0;
            done_r    <= 1'b1;
          end
        end
      end
    end

    assign src_o[g]   = src_r;
    assign dst_o[g]   = dst_r;
    assign last_o[g]  = (cnt_r == ONE_C);
    assign burst_o[g] = mode_r.burst;
    assign ind_o[g]   = mode_r.indirect;
    assign elig_o[g]  = mode_r.en && (cnt_r != '0);
    assign done_o[g]  = done_r;
  end

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = CHW'(i);
      end
    end
  end

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  arb_any,
  input  logic [CHW-1:0]        arb_idx,
  input  logic [NCH-1:0][W-1:0] src_i,
  input  logic [NCH-1:0][W-1:0] dst_i,
  input  logic [NCH-1:0]        last_i,
  input  logic [NCH-1:0]        burst_i,
  input  logic [NCH-1:0]        ind_i,
  input  logic                  bus_gnt,
  input  logic                  mem_ack,
  input  logic [W-1:0]          mem_rdata,
  output logic                  bus_req,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [W-1:0]          mem_addr,
  output logic [W-1:0]          mem_wdata,
  output logic                  upd,
  output logic [CHW-1:0]        cur_ch,
  output logic                  cur_burst
);

  seq_state_e   state;
  logic [W-1:0] ptr_q;
  logic [W-1:0] data_q;
  logic         cur_ind;
  logic         cur_last;

  assign cur_ind   = ind_i[cur_ch];
  assign cur_burst = burst_i[cur_ch];
  assign cur_last  = last_i[cur_ch];
  assign upd       = (state == ST_WRITE) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bus_req <= 1'b0;
      cur_ch  <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (arb_any) begin
            cur_ch  <= arb_idx;
            bus_req <= 1'b1;
            state   <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          if (bus_gnt) state <= cur_ind ? ST_PTR : ST_READ;
        end
        ST_PTR: begin
          if (mem_ack) begin
            ptr_q <= mem_rdata;
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            data_q <= mem_rdata;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (cur_last || !cur_burst) begin
              bus_req <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              state <= cur_ind ? ST_PTR : ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == ST_PTR) || (state == ST_READ) || (state == ST_WRITE);
    mem_we    = (state == ST_WRITE);
    mem_wdata = data_q;
    case (state)
      ST_WRITE: mem_addr = dst_i[cur_ch];
      ST_READ:  mem_addr = cur_ind ? ptr_q : src_i[cur_ch];
      default:  mem_addr = src_i[cur_ch];
    endcase
  end

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int NCH = 4,
  parameter int W   = 32,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [W-1:0]   cfg_wdata,
  input  logic [NCH-1:0] dreq,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_req,
  output logic           mem_we,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  input  logic           mem_ack,
  output logic [NCH-1:0] done
);

  logic [NCH-1:0][W-1:0] src_v;
  logic [NCH-1:0][W-1:0] dst_v;
  logic [NCH-1:0]        last_v;
  logic [NCH-1:0]        burst_v;
  logic [NCH-1:0]        ind_v;
  logic [NCH-1:0]        elig_v;
  logic [NCH-1:0]        arb_req;
  logic                  arb_any;
  logic [CHW-1:0]        arb_idx;
  logic                  upd;
  logic [CHW-1:0]        cur_ch;
  logic                  cur_burst;

  assign arb_req = elig_v & dreq;

  dma4_chregs #(.NCH(NCH), .W(W), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .upd(upd), .upd_ch(cur_ch),
    .src_o(src_v), .dst_o(dst_v), .last_o(last_v), .burst_o(burst_v),
    .ind_o(ind_v), .elig_o(elig_v), .done_o(done)
  );

  dma4_arb #(.NCH(NCH)) u_arb (
    .req(arb_req), .any(arb_any), .idx(arb_idx)
  );

  dma4_seq #(.NCH(NCH), .W(W)) u_seq (
    .clk(clk), .rst(rst),
    .arb_any(arb_any), .arb_idx(arb_idx),
    .src_i(src_v), .dst_i(dst_v), .last_i(last_v), .burst_i(burst_v), .ind_i(ind_v),
    .bus_gnt(bus_gnt), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .upd(upd), .cur_ch(cur_ch), .cur_burst(cur_burst)
  );

endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
  parameter int NCH = 4,
  parameter int W   = 32,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_req,
  input logic           mem_we,
  input logic [W-1:0]   mem_addr,
  input logic           mem_ack,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] arb_req,
  input logic [CHW-1:0] cur_ch,
  input logic           cur_burst
);

  logic [NCH-1:0] low_mask;
  always_comb begin
    for (int i = 0; i < NCH; i++) low_mask[i] = (CHW'(i) < cur_ch);
  end

  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> (($past(arb_req) & low_mask) == '0)); // R1

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack)); // R2

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack && !cur_burst) |=> !bus_req); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |=> ((done & $past(done)) == '0)); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |-> !bus_req); // R7

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8

  AST_MEM_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (bus_req && bus_gnt)); // R10

endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH), .W(W), .CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .done(done), .arb_req(arb_req), .cur_ch(cur_ch), .cur_burst(cur_burst)
);

// File: tb/test_dma4_engine.sv
module test_dma4_engine;

  localparam int NCH = 4;
  localparam int W   = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [W-1:0]   cfg_wdata = '0;
  logic [NCH-1:0] dreq = '0;
  logic           bus_req;
  logic           bus_gnt;
  logic           mem_req;
  logic           mem_we;
  logic [W-1:0]   mem_addr;
  logic [W-1:0]   mem_wdata;
  logic [W-1:0]   mem_rdata;
  logic           mem_ack;
  logic [NCH-1:0] done;

  always #4 clk = ~clk;

  dma4_engine #(.NCH(NCH), .W(W)) i_dma4_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done)
  );

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mem [0:255];
  int acc_cnt, br_cnt, wr_n;
  int done_cnt [NCH];
  logic [7:0] wr_addr [0:63];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: random wait states, ack on the cycle the access completes
  assign mem_rdata = mem[mem_addr[7:0]];
  int wcnt = 0;
  logic pend = 1'b0;
  logic [W-1:0] p_addr;
  logic p_we;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      pend    <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      if (pend && (mem_addr != p_addr || mem_we != p_we)) chk(1'b0, "R8 held access", mem_addr, p_addr);
      if (wcnt == 0) begin
        mem_ack <= 1'b1;
        pend    <= 1'b0;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          if (wr_n < 64) wr_addr[wr_n] = mem_addr[7:0];
          wr_n++;
        end
        acc_cnt++;
        wcnt <= int'($urandom % 4);
      end else begin
        wcnt   <= wcnt - 1;
        pend   <= 1'b1;
        p_addr <= mem_addr;
        p_we   <= mem_we;
      end
    end else begin
      if (pend && !mem_ack) chk(1'b0, "R8 request dropped", {31'd0, mem_req}, 32'd1);
      mem_ack <= 1'b0;
      pend    <= 1'b0;
    end
  end

  // bus grant model and port monitors
  int gd = 0;
  logic prev_br = 1'b0;
  logic [NCH-1:0] prev_done = '0;
  always @(negedge clk) begin
    if (rst) begin
      bus_gnt <= 1'b0;
      prev_br <= 1'b0;
      prev_done <= '0;
    end else begin
      if (mem_req && !(bus_req && bus_gnt)) chk(1'b0, "R10 access without grant", {31'd0, bus_gnt}, 32'd1);
      if (bus_req && !prev_br) br_cnt++;
      for (int c = 0; c < NCH; c++) begin
        if (done[c]) done_cnt[c]++;
        if (done[c] && prev_done[c]) chk(1'b0, "R7 done width", 32'd2, 32'd1);
      end
      prev_br   <= bus_req;
      prev_done <= done;
      if (!bus_req) begin
        bus_gnt <= 1'b0;
        gd <= int'($urandom % 3);
      end else if (gd == 0) bus_gnt <= 1'b1;
      else gd <= gd - 1;
    end
  end

  function automatic logic [W-1:0] mode_word(input bit en, input bit bu, input bit ind, input int ss, input int ds);
    return W'({ds[1:0], ss[1:0], ind, bu, en});
  endfunction

  function automatic int step_k(input int base, input int s, input int k);
    if (s == 1) return base + k;
    if (s == 2) return base - k;
    return base;
  endfunction

  task automatic cfg_wr(input int ch, input int sel, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch[1:0]; cfg_sel = sel[1:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_counts();
    acc_cnt = 0; br_cnt = 0; wr_n = 0;
    for (int c = 0; c < NCH; c++) done_cnt[c] = 0;
  endtask

  task automatic wait_done(input int ch);
    for (int t = 0; t < 3000 && done_cnt[ch] == 0; t++) @(negedge clk);
    if (done_cnt[ch] == 0) chk(1'b0, "R7 done timeout", 32'd0, 32'd1);
  endtask

  task automatic do_xfer(input int ch, input int sb, input int ss, input int db, input int ds,
                         input int n, input bit bu, input bit ind);
    logic [W-1:0] sv;
    int sa;
    for (int a = 128; a < 200; a++) mem[a] = '0;
    cfg_wr(ch, 0, W'(sb));
    cfg_wr(ch, 1, W'(db));
    cfg_wr(ch, 2, W'(n));
    cfg_wr(ch, 3, mode_word(1'b1, bu, ind, ss, ds));
    clear_counts();
    dreq[ch] = 1'b1;
    wait_done(ch);
    dreq = '0;
    repeat (4) @(negedge clk);
    chk(done_cnt[ch] == 1, "R7 one done pulse", W'(done_cnt[ch]), 32'd1);
    if (bu) chk(br_cnt == 1, "R5 bus held for burst", W'(br_cnt), 32'd1);
    else    chk(br_cnt == n, "R4 bus released per unit", W'(br_cnt), W'(n));
    chk(acc_cnt == n * (ind ? 3 : 2), ind ? "R3 pointer access count" : "R2 access count",
        W'(acc_cnt), W'(n * (ind ? 3 : 2)));
    for (int k = 0; k < n; k++) begin
      if (ds == 0 && k != n - 1) continue;
      sa = step_k(sb, ss, k);
      if (ind) sa = int'(mem[sa][7:0]);
      sv = mem[sa];
      chk(mem[step_k(db, ds, k)] == sv, ind ? "R3 data via pointer" : "R6 R2 unit data",
          mem[step_k(db, ds, k)], sv);
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd715);
    for (int i = 0; i < 64; i++) mem[i] = 32'hD000_0000 + i * 32'h0001_0203;
    for (int i = 64; i < 128; i++) mem[i] = W'(8 + (i * 5) % 56);
    for (int i = 128; i < 256; i++) mem[i] = '0;
    clear_counts();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(bus_req == 1'b0, "R10 reset bus_req", {31'd0, bus_req}, 32'd0);
    chk(mem_req == 1'b0, "R10 reset mem_req", {31'd0, mem_req}, 32'd0);
    chk(done == '0, "R7 reset done", W'(done), 32'd0);

    // directed: stepping and bus modes, R2 R4 R5 R6
    do_xfer(1, 16, 1, 140, 1, 4, 1'b0, 1'b0);
    do_xfer(2, 40, 2, 150, 0, 3, 1'b1, 1'b0);
    do_xfer(0, 20, 0, 180, 2, 3, 1'b0, 1'b0);
    // directed: indirect source, R3
    do_xfer(3, 80, 1, 160, 1, 3, 1'b0, 1'b1);
    do_xfer(3, 90, 2, 170, 1, 2, 1'b1, 1'b1);

    // R7: finished channel ignores further requests
    clear_counts();
    dreq = 4'b0010;
    repeat (40) @(negedge clk);
    dreq = '0;
    chk(br_cnt == 0, "R7 disarmed after last unit", W'(br_cnt), 32'd0);

    // R9: disabled channel, then zero-count channel
    cfg_wr(1, 0, 32'd5); cfg_wr(1, 1, 32'd190); cfg_wr(1, 2, 32'd2);
    cfg_wr(1, 3, mode_word(1'b0, 1'b0, 1'b0, 1, 1));
    mem[190] = '0;
    clear_counts();
    dreq = 4'b0010;
    repeat (40) @(negedge clk);
    chk(br_cnt == 0, "R9 disabled channel ignored", W'(br_cnt), 32'd0);
    cfg_wr(1, 2, 32'd0);
    cfg_wr(1, 3, mode_word(1'b1, 1'b0, 1'b0, 1, 1));
    repeat (40) @(negedge clk);
    dreq = '0;
    chk(br_cnt == 0, "R9 zero count ignored", W'(br_cnt), 32'd0);
    chk(mem[190] == '0, "R9 no write", mem[190], 32'd0);

    // R1: simultaneous requests on channels 0 and 2
    cfg_wr(0, 0, 32'd10); cfg_wr(0, 1, 32'd150); cfg_wr(0, 2, 32'd1);
    cfg_wr(0, 3, mode_word(1'b1, 1'b0, 1'b0, 1, 1));
    cfg_wr(2, 0, 32'd12); cfg_wr(2, 1, 32'd155); cfg_wr(2, 2, 32'd1);
    cfg_wr(2, 3, mode_word(1'b1, 1'b0, 1'b0, 1, 1));
    clear_counts();
    dreq = 4'b0101;
    wait_done(0);
    wait_done(2);
    dreq = '0;
    chk(wr_addr[0] == 8'd150, "R1 channel 0 first", W'(wr_addr[0]), 32'd150);
    chk(wr_addr[1] == 8'd155, "R1 channel 2 second", W'(wr_addr[1]), 32'd155);

    // R5: late higher-priority request waits for the burst
    cfg_wr(3, 0, 32'd30); cfg_wr(3, 1, 32'd170); cfg_wr(3, 2, 32'd3);
    cfg_wr(3, 3, mode_word(1'b1, 1'b1, 1'b0, 1, 1));
    cfg_wr(0, 0, 32'd11); cfg_wr(0, 1, 32'd180); cfg_wr(0, 2, 32'd1);
    cfg_wr(0, 3, mode_word(1'b1, 1'b0, 1'b0, 1, 1));
    clear_counts();
    dreq = 4'b1000;
    for (int t = 0; t < 500 && wr_n == 0; t++) @(negedge clk);
    dreq = 4'b1001;
    wait_done(3);
    wait_done(0);
    dreq = '0;
    for (int k = 0; k < 3; k++)
      chk(wr_addr[k] == 8'(170 + k), "R5 burst not preempted", W'(wr_addr[k]), W'(170 + k));
    chk(wr_addr[3] == 8'd180, "R5 preempting channel after burst", W'(wr_addr[3]), 32'd180);

    // constrained random transfers, R2 R3 R4 R5 R6 R7
    for (int it = 0; it < 24; it++) begin
      int ch, n, ss, ds, sb, db;
      bit bu, ind;
      ch  = int'($urandom % 4);
      n   = 1 + int'($urandom % 6);
      ss  = int'($urandom % 3);
      ds  = int'($urandom % 3);
      bu  = 1'($urandom % 2);
      ind = 1'($urandom % 2);
      sb  = ind ? 70 + int'($urandom % 20) : 8 + int'($urandom % 48);
      db  = 136 + int'($urandom % 48);
      do_xfer(ch, sb, ss, db, ds, n, bu, ind);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule